// File: doc/BRIEF.md
# Dual-Channel DAC Serial Register Interface

This block is the digital front end of a two-channel 12-bit voltage DAC. A host writes 16-bit frames over a three-wire serial link made of an active-low frame select, a serial clock and a data line. Each completed frame is decoded into one of four operations. It can load a channel's holding register. It can load the holding register and pass the code straight to that channel's output register. It can transfer both holding registers to the output registers in the same cycle. It can change a channel's power-down flag. The two output codes and the two power-down flags drive the analog section.

The serial pins are brought into the block's system clock domain through short synchronizer chains, and edges are found by comparing successive samples. A 16-bit shift register collects the bits and also feeds the serial data output, so that several devices can be chained on one link. An active-low clear input forces both output codes to zero with no clock needed. The power-on reset returns every register to zero.

Top module: `dual_dac_serial`

## Requirements
- R1: A frame starts when frame_n falls. While frame_n is low, one bit is taken from sdi on each falling edge of sck, most significant bit first. The frame is acted on when frame_n rises.
- R2: Opcode 00 (bits [15:14]) writes code bits [11:0] into the holding register of the channel picked by bit 12 (0 = A, 1 = B). Both output codes stay unchanged.
- R3: Opcode 01 writes the code into the picked channel's holding register and its output code. The other channel is untouched.
- R4: Opcode 10 copies both holding registers into both output codes on the same clock edge. Bits [12:0] are ignored.
- R5: Opcode 11 sets the power-down flag of the picked channel to bit 0 (1 = powered down) and leaves all codes unchanged. No other opcode changes a power-down flag.
- R6: A frame that ends after fewer than 16 sampled sck falling edges changes no register.
- R7: A frame with more than 16 sampled edges is decoded from the last 16 bits received.
- R8: While chain_en is high, sdo shows bit 15 of a shift register that holds the last 16 bits received. sdo changes only after a sampled sck falling edge. While chain_en is low, sdo is 0.
- R9: While clr_n is low, both output codes are zero, with no clock edge needed. Holding registers and power-down flags keep their values.
- R10: After reset, both output codes are 0, both power-down flags are 0 and sdo is 0.
- R11: Outputs take the value of a completed frame by the fourth clk edge after frame_n rises.
- R12: Codes 000h and FFFh are passed through without change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| clr_n | input | 1 | Clear of both output codes, active low, asynchronous |
| frame_n | input | 1 | Frame select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| chain_en | input | 1 | Enables the daisy-chain output |
| sdo | output | 1 | Serial data out |
| code_a | output | 12 | Output code, channel A |
| code_b | output | 12 | Output code, channel B |
| pd_a | output | 1 | Power-down flag, channel A |
| pd_b | output | 1 | Power-down flag, channel B |

## Verification
The assertions assume that every serial pin level lasts longer than the synchronizer depth. They also assume that sdi is steady across each sck falling edge, that chain_en changes only between frames, and that a clr_n pulse spans at least one clk edge. The stimulus holds each sck phase for four clk cycles and changes sdi only on the sck rising half. It toggles chain_en and pulses clr_n only while frame_n is high. Frame lengths are drawn around 16 so that short and long frames both occur.

// File: rtl/dual_dac_serial.sv
module dual_dac_serial #(
  parameter int WORD_W = 16,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              frame_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              chain_en,
  output logic              sdo,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              pd_a,
  output logic              pd_b
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [2:0] sck_p, fs_p;
  logic [1:0] sdi_p;
  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0] cnt;
  logic [CODE_W-1:0] hold_a, hold_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p <= '0;
      fs_p  <= '1;
      sdi_p <= '0;
    end else begin
      sck_p <= {sck_p[1:0], sck};
      fs_p  <= {fs_p[1:0], frame_n};
      sdi_p <= {sdi_p[0], sdi};
    end

  wire sck_fall = sck_p[2] & ~sck_p[1];
  wire fs_fall  = fs_p[2] & ~fs_p[1];
  wire fs_rise  = ~fs_p[2] & fs_p[1];
  wire fs_low   = ~fs_p[1];
  wire shift_en = fs_low & sck_fall;
  wire commit   = fs_rise & (cnt == FULL);

  wire [1:0]        op   = sr[WORD_W-1 -: 2];
  wire              ch_b = sr[WORD_W-4];
  wire [CODE_W-1:0] code = sr[CODE_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else begin
      if (shift_en) sr <= {sr[WORD_W-2:0], sdi_p[1]};
      if (fs_fall)
        cnt <= shift_en ? CNT_W'(1) : '0;
      else if (shift_en && cnt != FULL)
        cnt <= cnt + 1'b1;
    end

  assign sdo = chain_en & sr[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold_a <= '0;
      hold_b <= '0;
      pd_a   <= 1'b0;
      pd_b   <= 1'b0;
    end else if (commit) begin
      if (op == 2'b00 || op == 2'b01) begin
        if (ch_b) hold_b <= code;
        else      hold_a <= code;
      end else if (op == 2'b11) begin
        if (ch_b) pd_b <= sr[0];
        else      pd_a <= sr[0];
      end
    end

  always_ff @(posedge clk or negedge rst_n or negedge clr_n)
    if (!rst_n) begin
      code_a <= '0;
      code_b <= '0;
    end else if (!clr_n) begin
      code_a <= '0;
      code_b <= '0;
    end else if (commit) begin
      if (op == 2'b01) begin
        if (ch_b) code_b <= code;
        else      code_a <= code;
      end else if (op == 2'b10) begin
        code_a <= hold_a;
        code_b <= hold_b;
      end
    end

  // R9: clear holds both output codes at zero
  p_clr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (code_a == '0 && code_b == '0));

  // R6: a short frame leaves every register as it was
  p_short_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_rise && cnt != FULL) |=> ($stable(hold_a) && $stable(hold_b) &&
      $stable(pd_a) && $stable(pd_b) &&
      (!clr_n || ($stable(code_a) && $stable(code_b)))));

  // R3: an output code moves only after a committed frame or a clear
  p_code_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && $past(clr_n) && (code_a != $past(code_a) || code_b != $past(code_b)))
      |-> $past(commit));

  // R4: both output codes load from the holding registers together
  p_load_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && op == 2'b10 && clr_n) |=>
      (!clr_n || (code_a == $past(hold_a) && code_b == $past(hold_b))));

  // R5: power-down flags move only on an opcode 11 frame
  p_pd_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_a != $past(pd_a) || pd_b != $past(pd_b)) |-> $past(commit && op == 2'b11));

  // R8: the chained output moves only after a sampled clock edge
  p_sdo_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_en && $past(chain_en) && sdo != $past(sdo)) |-> $past(shift_en));
endmodule

// File: tb/test_dual_dac_serial.sv
module test_dual_dac_serial;
  localparam int H = 4;
  logic clk = 0, rst_n = 0, clr_n = 1, frame_n = 1, sck = 0, sdi = 0, chain_en = 0;
  logic sdo, pd_a, pd_b;
  logic [11:0] code_a, code_b;
  int total = 0, bad = 0;
  logic [15:0] sr_m = '0;
  logic [11:0] e_ha = 0, e_hb = 0, e_ca = 0, e_cb = 0;
  logic e_pa = 0, e_pb = 0;

  always #5 clk = ~clk;

  dual_dac_serial i_dual_dac_serial (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .frame_n(frame_n), .sck(sck),
    .sdi(sdi), .chain_en(chain_en), .sdo(sdo), .code_a(code_a), .code_b(code_b),
    .pd_a(pd_a), .pd_b(pd_b));

  function automatic logic [15:0] mk(input logic [1:0] op, input logic ch, input logic [11:0] c);
    return {op, 1'b0, ch, c};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_model();
    logic [11:0] c = sr_m[11:0];
    case (sr_m[15:14])
      2'b00: if (sr_m[12]) e_hb = c; else e_ha = c;
      2'b01: if (sr_m[12]) begin e_hb = c; e_cb = c; end else begin e_ha = c; e_ca = c; end
      2'b10: begin e_ca = e_ha; e_cb = e_hb; end
      default: if (sr_m[12]) e_pb = sr_m[0]; else e_pa = sr_m[0];
    endcase
  endtask

  task automatic check_outs(input string req);
    chk({req, " code_a"}, {4'h0, code_a}, {4'h0, e_ca});
    chk({req, " code_b"}, {4'h0, code_b}, {4'h0, e_cb});
    chk({req, " pd"}, {14'h0, pd_b, pd_a}, {14'h0, e_pb, e_pa});
  endtask

  task automatic send(input logic [31:0] v, input int n, input string req);
    @(negedge clk) frame_n = 0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = v[n-1-i];
      sck = 1;
      repeat (H) @(negedge clk);
      sck = 0;
      sr_m = {sr_m[14:0], v[n-1-i]};
      repeat (H) @(negedge clk);
      chk("R8 sdo", {15'h0, sdo}, {15'h0, chain_en & sr_m[15]});
    end
    frame_n = 1;
    if (n >= 16) apply_model();
    repeat (H) @(negedge clk);
    check_outs({req, " R1 R11"});
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_pulse();
    @(negedge clk) clr_n = 0;
    #1;
    chk("R9 async clear", {code_b[3:0], code_a}, 16'h0);
    e_ca = 0; e_cb = 0;
    repeat (3) @(negedge clk);
    check_outs("R9 held");
    clr_n = 1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed, n;
    logic [31:0] v;
    seed = $urandom(32'h5eed1);
    repeat (3) @(negedge clk);
    chk("R10 reset sdo", {15'h0, sdo}, 16'h0);
    check_outs("R10 reset");
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_outs("R10 after release");

    send({16'h0, mk(2'b00, 0, 12'hABC)}, 16, "R2 hold only");
    send({16'h0, mk(2'b01, 1, 12'hFFF)}, 16, "R3 R12 direct B");
    send({16'h0, mk(2'b10, 1, 12'h555)}, 16, "R4 load both");
    chk("R4 code_a", {4'h0, code_a}, 16'h0ABC);
    send({16'h0, mk(2'b01, 0, 12'h000)}, 16, "R12 zero code");
    send({16'h0, mk(2'b01, 0, 12'h3C3)}, 10, "R6 short frame");
    chk("R6 code_a kept", {4'h0, code_a}, 16'h0);
    send({16'hDEAD, mk(2'b01, 0, 12'h7E1)}, 24, "R7 long frame");
    chk("R7 last bits", {4'h0, code_a}, 16'h07E1);
    send({16'h0, mk(2'b11, 0, 12'h001)}, 16, "R5 pd A on");
    send({16'h0, mk(2'b11, 1, 12'h001)}, 16, "R5 pd B on");
    send({16'h0, mk(2'b11, 0, 12'h000)}, 16, "R5 pd A off");
    chain_en = 1;
    send({16'h0, mk(2'b00, 1, 12'h9A5)}, 16, "R8 chain");
    send({16'h0, mk(2'b00, 0, 12'h6B2)}, 16, "R8 chain prev word");
    clear_pulse();
    send({16'h0, mk(2'b10, 0, 12'h000)}, 16, "R9 holds kept");
    chk("R9 code_b restored", {4'h0, code_b}, 16'h09A5);

    for (int k = 0; k < 150; k++) begin
      v = $urandom;
      n = (k % 9 == 0) ? 8 + ($urandom % 8) : (k % 11 == 0) ? 17 + ($urandom % 10) : 16;
      chain_en = $urandom % 2;
      send(v, n, "random");
      if (k % 13 == 0) clear_pulse();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule